// File: doc/BRIEF.md
# Address Translation Buffer with Context Tags

This block translates virtual addresses to physical addresses through a table of 64 translations. Any entry can hold any translation, and a lookup compares every entry in parallel. Each entry carries a 6-bit context tag, a 20-bit virtual page number, a 20-bit physical frame number and four status flags: valid, writable, dirty and referenced. A match needs all three of these: the entry is valid, the page number agrees, and the context tag agrees. Translations from different processes can therefore stay resident across a context switch.

The three most significant address bits select the segment. When bit 31 is 0 the address is in mapped user space. The value 100 selects cached direct kernel space and 101 selects uncached direct kernel space; neither of these goes through the table. The value 11x selects mapped kernel space. A miss goes to a software handler, which installs a translation at an index it chooses through a plain write port.

Lookups use a valid/ready request channel and a valid/ready response channel, and the response is registered. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high when no response is held, or when the held response is being taken in that same cycle. A held response stays stable until `rsp_ready` is high. Status updates happen only on accepted requests.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at one clock edge produces its response after that edge. A mapped request hits only on an entry that is valid and whose page number (va[31:12]) and context tag both equal the request's. On a hit `rsp_pa` = {frame, va[11:0]}.
- R3: An entry installed under one context tag never hits a request carrying another tag. Entries with the same page and different tags coexist, and each returns its own frame.
- R4: If va[31:29] is 100 or 101 the response always has hit=1, mapped=0, ref=0, dirty=0, writable=1 and `rsp_pa` = {3'b000, va[28:0]}, whatever the table holds. `rsp_uncached` is 1 only for 101. If va[31]=0 or va[31:30]=11 the request is mapped (mapped=1).
- R5: A write-port install at an index is seen by lookups in the following cycle. A lookup in the same cycle as the install sees the old contents.
- R6: Every mapped hit sets the entry's referenced flag, and the response reports ref=1.
- R7: A store hit on a writable entry sets its dirty flag. The response and later lookups report dirty=1.
- R8: A store hit on a read-only entry gives `rsp_prot_fault`=1 and leaves dirty at 0. A load never faults.
- R9: When several entries match, the entry with the lowest index supplies the response.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the response is held stable and `req_ready`=0. A request offered during that time is not accepted and updates no entry.
- R11: A mapped miss reports hit=0, pa=0, dirty=0, ref=0, writable=0 and fault=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_asid | input | 6 | Context tag of the request |
| req_va | input | 32 | Virtual address |
| req_store | input | 1 | Request is a store (1) or a load (0) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Translation found or address unmapped |
| rsp_pa | output | 32 | Physical address |
| rsp_dirty | output | 1 | Dirty flag after this access |
| rsp_ref | output | 1 | Referenced flag after this access |
| rsp_writable | output | 1 | Page permits stores |
| rsp_mapped | output | 1 | Address lies in a translated segment |
| rsp_uncached | output | 1 | Address lies in uncached direct space |
| rsp_prot_fault | output | 1 | Store hit a read-only page |
| wr_en | input | 1 | Install an entry |
| wr_idx | input | 6 | Entry index to install |
| wr_asid | input | 6 | Context tag to install |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_pfn | input | 20 | Physical frame to install |
| wr_valid | input | 1 | Valid flag to install |
| wr_writable | input | 1 | Writable flag to install |
| wr_dirty | input | 1 | Dirty flag to install |
| wr_ref | input | 1 | Referenced flag to install |

## Verification
Two situations are the hardest to reach from the ports. The first is an install and a lookup of the same translation in the same cycle. The stimulus drives the write port and the request channel on the same clock edge, then repeats the lookup alone to show that the install only lands in the next cycle. The second is a store that is refused under back-pressure. The bench keeps `rsp_ready` low so that a store to a writable page waits for several cycles, then withdraws the store. A later load then shows that the dirty flag was never set, and meanwhile the held response must not change.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Address segment chosen by the three most significant bits
  typedef enum logic [1:0] {
    SEG_USER    = 2'd0,
    SEG_DIRECT  = 2'd1,
    SEG_RAW     = 2'd2,
    SEG_KMAPPED = 2'd3
  } seg_e;

  // Status carried by each translation
  typedef struct packed {
    logic vld;
    logic wr_ok;
    logic dirty;
    logic refd;
  } flags_t;

endpackage

// File: rtl/xlat_seg_decode.sv
module xlat_seg_decode
  import xlat_pkg::*;
(
  input  logic [2:0] top_bits,
  output logic       mapped,
  output logic       uncached
);

  seg_e seg;

  always_comb begin
    if (!top_bits[2])      seg = SEG_USER;
    else if (top_bits[1])  seg = SEG_KMAPPED;
    else if (top_bits[0])  seg = SEG_RAW;
    else                   seg = SEG_DIRECT;
  end

  assign mapped   = (seg == SEG_USER) || (seg == SEG_KMAPPED);
  assign uncached = (seg == SEG_RAW);

endmodule

// File: rtl/xlat_hit_encode.sv
module xlat_hit_encode #(
  parameter int ENTRIES = 64,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] match_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   hit_idx
);

  // Lowest set index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) hit_idx = i[IDX_W-1:0];
    end
  end

  assign any_hit = |match_vec;

  // R9: the chosen entry really matches and no lower one does
  a_r9_pick_matches: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> match_vec[hit_idx]);
  a_r9_none_below: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> ((match_vec & ~({ENTRIES{1'b1}} << hit_idx)) == '0));

endmodule

// File: rtl/xlat_entry_array.sv
module xlat_entry_array
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  // install port
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic [VPN_W-1:0]   wr_vpn,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  flags_t             wr_flags,
  // status update from an accepted hit
  input  logic               upd_en,
  input  logic [IDX_W-1:0]   upd_idx,
  input  logic               upd_set_dirty,
  // parallel compare
  input  logic [ASID_W-1:0]  cmp_asid,
  input  logic [VPN_W-1:0]   cmp_vpn,
  output logic [ENTRIES-1:0] match_vec,
  // read of the selected entry
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [PFN_W-1:0]   rd_pfn,
  output flags_t             rd_flags
);

  logic [PFN_W-1:0] ent_pfn   [ENTRIES];
  flags_t           ent_flags [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic [ASID_W-1:0] asid_q;
    logic [VPN_W-1:0]  vpn_q;
    logic [PFN_W-1:0]  pfn_q;
    flags_t            flg_q;
    logic              wr_here;
    logic              upd_here;

    assign wr_here  = wr_en  && (wr_idx  == IDX_W'(g));
    assign upd_here = upd_en && (upd_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (wr_here) begin
        asid_q <= wr_asid;
        vpn_q  <= wr_vpn;
        pfn_q  <= wr_pfn;
      end
    end

    // An install wins over a status update to the same entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flg_q <= '0;
      end else if (wr_here) begin
        flg_q <= wr_flags;
      end else if (upd_here) begin
        flg_q.refd <= 1'b1;
        if (upd_set_dirty) flg_q.dirty <= 1'b1;
      end
    end

    assign match_vec[g] = flg_q.vld && (vpn_q == cmp_vpn) && (asid_q == cmp_asid);
    assign ent_pfn[g]   = pfn_q;
    assign ent_flags[g] = flg_q;
  end

  assign rd_pfn   = ent_pfn[rd_idx];
  assign rd_flags = ent_flags[rd_idx];

  // R5: an install is visible in the following cycle
  a_r5_install_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_flags[$past(wr_idx)] == $past(wr_flags));

  // R6: an update without a competing install leaves the entry referenced
  a_r6_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && !(wr_en && wr_idx == upd_idx)) |=> ent_flags[$past(upd_idx)].refd);

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ASID_W  = 6,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int DIR_W  = VA_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [VA_W-1:0]   req_va,
  input  logic              req_store,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_dirty,
  output logic              rsp_ref,
  output logic              rsp_writable,
  output logic              rsp_mapped,
  output logic              rsp_uncached,
  output logic              rsp_prot_fault,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PFN_W-1:0]  wr_pfn,
  input  logic              wr_valid,
  input  logic              wr_writable,
  input  logic              wr_dirty,
  input  logic              wr_ref
);

  logic               accept;
  logic               seg_mapped;
  logic               seg_uncached;
  logic [ENTRIES-1:0] match_vec;
  logic               any_hit;
  logic [IDX_W-1:0]   hit_idx;
  logic [PFN_W-1:0]   sel_pfn;
  flags_t             sel_flags;
  flags_t             wr_flags;
  logic               tlb_hit;
  logic               set_dirty;
  logic               fault;
  logic [PA_W-1:0]    direct_pa;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign wr_flags = '{vld: wr_valid, wr_ok: wr_writable, dirty: wr_dirty, refd: wr_ref};

  xlat_seg_decode u_seg (
    .top_bits (req_va[VA_W-1 -: 3]),
    .mapped   (seg_mapped),
    .uncached (seg_uncached)
  );

  xlat_entry_array #(
    .ENTRIES (ENTRIES),
    .ASID_W  (ASID_W),
    .VPN_W   (VPN_W),
    .PFN_W   (PFN_W)
  ) u_array (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_idx        (wr_idx),
    .wr_asid       (wr_asid),
    .wr_vpn        (wr_vpn),
    .wr_pfn        (wr_pfn),
    .wr_flags      (wr_flags),
    .upd_en        (accept && tlb_hit),
    .upd_idx       (hit_idx),
    .upd_set_dirty (set_dirty),
    .cmp_asid      (req_asid),
    .cmp_vpn       (req_va[VA_W-1:OFF_W]),
    .match_vec     (match_vec),
    .rd_idx        (hit_idx),
    .rd_pfn        (sel_pfn),
    .rd_flags      (sel_flags)
  );

  xlat_hit_encode #(
    .ENTRIES (ENTRIES)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_vec (match_vec),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  assign tlb_hit   = seg_mapped && any_hit;
  assign set_dirty = req_store && sel_flags.wr_ok;
  assign fault     = tlb_hit && req_store && !sel_flags.wr_ok;
  assign direct_pa = PA_W'(req_va[DIR_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit        <= 1'b0;
      rsp_pa         <= '0;
      rsp_dirty      <= 1'b0;
      rsp_ref        <= 1'b0;
      rsp_writable   <= 1'b0;
      rsp_mapped     <= 1'b0;
      rsp_uncached   <= 1'b0;
      rsp_prot_fault <= 1'b0;
    end else if (accept) begin
      rsp_mapped     <= seg_mapped;
      rsp_uncached   <= seg_uncached;
      rsp_prot_fault <= fault;
      if (!seg_mapped) begin
        rsp_hit      <= 1'b1;
        rsp_pa       <= direct_pa;
        rsp_dirty    <= 1'b0;
        rsp_ref      <= 1'b0;
        rsp_writable <= 1'b1;
      end else if (tlb_hit) begin
        rsp_hit      <= 1'b1;
        rsp_pa       <= {sel_pfn, req_va[OFF_W-1:0]};
        rsp_dirty    <= sel_flags.dirty || set_dirty;
        rsp_ref      <= 1'b1;
        rsp_writable <= sel_flags.wr_ok;
      end else begin
        rsp_hit      <= 1'b0;
        rsp_pa       <= '0;
        rsp_dirty    <= 1'b0;
        rsp_ref      <= 1'b0;
        rsp_writable <= 1'b0;
      end
    end
  end

  // R10: a stalled response does not move
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_hit)
                                   && $stable(rsp_dirty)));
  // R8: a fault only comes from a hit on a read-only page
  a_r8_fault_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_prot_fault) |-> (rsp_hit && rsp_mapped && !rsp_writable));
  // R4: untranslated space always hits with a zero top field
  a_r4_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_mapped) |-> (rsp_hit && !rsp_ref && rsp_pa[PA_W-1 -: 3] == 3'b000));
  // R11: a miss carries no status
  a_r11_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_pa == '0 && !rsp_ref && !rsp_dirty && !rsp_prot_fault));
  // R7: a store that did not fault reports a dirty page
  a_r7_store_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tlb_hit && req_store && sel_flags.wr_ok) |=> rsp_dirty);

endmodule

// File: tb/xlat_tlb_tb.sv
`timescale 1ns/1ps
module xlat_tlb_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [5:0]  req_asid = '0;
  logic [31:0] req_va = '0;
  logic        req_store = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit, rsp_dirty, rsp_ref, rsp_writable;
  logic        rsp_mapped, rsp_uncached, rsp_prot_fault;
  logic [31:0] rsp_pa;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [5:0]  wr_asid = '0;
  logic [19:0] wr_vpn = '0;
  logic [19:0] wr_pfn = '0;
  logic        wr_valid = 1'b0, wr_writable = 1'b0, wr_dirty = 1'b0, wr_ref = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xlat_tlb u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_asid(req_asid),
    .req_va(req_va), .req_store(req_store),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_pa(rsp_pa), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref),
    .rsp_writable(rsp_writable), .rsp_mapped(rsp_mapped),
    .rsp_uncached(rsp_uncached), .rsp_prot_fault(rsp_prot_fault),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_asid(wr_asid), .wr_vpn(wr_vpn),
    .wr_pfn(wr_pfn), .wr_valid(wr_valid), .wr_writable(wr_writable),
    .wr_dirty(wr_dirty), .wr_ref(wr_ref)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic set_wr(input logic [5:0] idx, input logic [5:0] asid,
                        input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic v, input logic w, input logic d, input logic r);
    wr_en = 1'b1; wr_idx = idx; wr_asid = asid; wr_vpn = vpn; wr_pfn = pfn;
    wr_valid = v; wr_writable = w; wr_dirty = d; wr_ref = r;
  endtask

  task automatic install(input logic [5:0] idx, input logic [5:0] asid,
                         input logic [19:0] vpn, input logic [19:0] pfn,
                         input logic v, input logic w, input logic d, input logic r);
    @(negedge clk);
    set_wr(idx, asid, vpn, pfn, v, w, d, r);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one accepted request; response is sampled one negedge later
  task automatic lookup(input logic [5:0] asid, input logic [31:0] va, input logic st);
    @(negedge clk);
    req_valid = 1'b1; req_asid = asid; req_va = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    lookup(6'd0, 32'h0000_0000, 1'b0);
    chk("R1", "hit on empty table", 32'(rsp_hit), 32'd0);
    chk("R11", "miss pa", rsp_pa, 32'd0);
  endtask

  task automatic t_basic;
    install(6'd5, 6'd3, 20'h12345, 20'hABCDE, 1, 1, 0, 0);
    lookup(6'd3, 32'h1234_5678, 1'b0);
    chk("R2", "rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R2", "hit", 32'(rsp_hit), 32'd1);
    chk("R2", "pa", rsp_pa, 32'hABCD_E678);
    chk("R6", "ref on hit", 32'(rsp_ref), 32'd1);
    chk("R2", "mapped user", 32'(rsp_mapped), 32'd1);
    chk("R8", "load no fault", 32'(rsp_prot_fault), 32'd0);
  endtask

  task automatic t_asid;
    lookup(6'd4, 32'h1234_5678, 1'b0);
    chk("R3", "other tag misses", 32'(rsp_hit), 32'd0);
    chk("R11", "miss ref", 32'(rsp_ref), 32'd0);
    install(6'd6, 6'd4, 20'h12345, 20'h11111, 1, 1, 0, 0);
    lookup(6'd4, 32'h1234_5678, 1'b0);
    chk("R3", "tag 4 frame", rsp_pa, 32'h1111_1678);
    lookup(6'd3, 32'h1234_5678, 1'b0);
    chk("R3", "tag 3 frame", rsp_pa, 32'hABCD_E678);
  endtask

  task automatic t_segments;
    install(6'd7, 6'd3, 20'h80001, 20'h55555, 1, 1, 0, 0);
    lookup(6'd3, 32'h8000_1234, 1'b0);
    chk("R4", "direct hit", 32'(rsp_hit), 32'd1);
    chk("R4", "direct pa ignores table", rsp_pa, 32'h0000_1234);
    chk("R4", "direct mapped", 32'(rsp_mapped), 32'd0);
    chk("R4", "direct cached", 32'(rsp_uncached), 32'd0);
    lookup(6'd3, 32'hBFFF_4321, 1'b0);
    chk("R4", "raw pa", rsp_pa, 32'h1FFF_4321);
    chk("R4", "raw uncached", 32'(rsp_uncached), 32'd1);
    lookup(6'd3, 32'hC000_2ABC, 1'b0);
    chk("R4", "kernel mapped miss", 32'(rsp_hit), 32'd0);
    chk("R4", "kernel mapped flag", 32'(rsp_mapped), 32'd1);
    install(6'd8, 6'd3, 20'hC0002, 20'h22222, 1, 1, 0, 0);
    lookup(6'd3, 32'hC000_2ABC, 1'b0);
    chk("R4", "kernel mapped pa", rsp_pa, 32'h2222_2ABC);
  endtask

  task automatic t_dirty;
    lookup(6'd3, 32'h1234_5000, 1'b1);
    chk("R7", "store dirty", 32'(rsp_dirty), 32'd1);
    chk("R7", "store no fault", 32'(rsp_prot_fault), 32'd0);
    lookup(6'd3, 32'h1234_5004, 1'b0);
    chk("R7", "dirty kept", 32'(rsp_dirty), 32'd1);
  endtask

  task automatic t_readonly;
    install(6'd9, 6'd2, 20'h00400, 20'h33333, 1, 0, 0, 0);
    lookup(6'd2, 32'h0040_0010, 1'b1);
    chk("R8", "fault", 32'(rsp_prot_fault), 32'd1);
    chk("R8", "hit", 32'(rsp_hit), 32'd1);
    chk("R8", "dirty on fault", 32'(rsp_dirty), 32'd0);
    lookup(6'd2, 32'h0040_0010, 1'b0);
    chk("R8", "dirty after fault", 32'(rsp_dirty), 32'd0);
    chk("R8", "load fault", 32'(rsp_prot_fault), 32'd0);
    install(6'd10, 6'd2, 20'h00500, 20'h77777, 0, 1, 0, 0);
    lookup(6'd2, 32'h0050_0000, 1'b0);
    chk("R2", "invalid entry misses", 32'(rsp_hit), 32'd0);
  endtask

  task automatic t_race;
    @(negedge clk);
    set_wr(6'd11, 6'd1, 20'h00600, 20'h99999, 1, 1, 0, 0);
    req_valid = 1'b1; req_asid = 6'd1; req_va = 32'h0060_0ABC; req_store = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    chk("R5", "same-cycle install unseen", 32'(rsp_hit), 32'd0);
    lookup(6'd1, 32'h0060_0ABC, 1'b0);
    chk("R5", "install seen next", rsp_pa, 32'h9999_9ABC);
  endtask

  task automatic t_priority;
    install(6'd20, 6'd1, 20'h00700, 20'h44444, 1, 1, 0, 0);
    install(6'd12, 6'd1, 20'h00700, 20'h66666, 1, 1, 0, 0);
    lookup(6'd1, 32'h0070_0001, 1'b0);
    chk("R9", "lowest index", rsp_pa, 32'h6666_6001);
    install(6'd12, 6'd1, 20'h00700, 20'h66666, 0, 1, 0, 0);
    lookup(6'd1, 32'h0070_0001, 1'b0);
    chk("R9", "next match", rsp_pa, 32'h4444_4001);
  endtask

  task automatic t_backpressure;
    install(6'd13, 6'd5, 20'h00800, 20'h88888, 1, 1, 0, 0);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_asid = 6'd5; req_va = 32'h0080_0020; req_store = 1'b0;
    @(negedge clk);
    req_asid = 6'd5; req_va = 32'h0080_0040; req_store = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R10", "req_ready low", 32'(req_ready), 32'd0);
      chk("R10", "held pa", rsp_pa, 32'h8888_8020);
    end
    chk("R10", "held dirty", 32'(rsp_dirty), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R10", "drained", 32'(rsp_valid), 32'd0);
    lookup(6'd5, 32'h0080_0000, 1'b0);
    chk("R10", "stalled store had no effect", 32'(rsp_dirty), 32'd0);
    chk("R6", "ref set", 32'(rsp_ref), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_asid();
    t_segments();
    t_dirty();
    t_readonly();
    t_race();
    t_priority();
    t_backpressure();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule